// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a processor's store port and its data cache. A store to a line the cache does not yet own for writing is parked in a small in-order queue, and the processor continues without waiting for the coherence exchange. The block asks the cache to obtain ownership for the oldest parked store whose line is not yet writable. Each entry drains into the cache once the cache has reported ownership of its line. When the queue is empty and the line is already writable, a store goes straight to the cache in the same cycle.

Loads look into the queue before the cache result is used, so a processor always reads its own latest stores. Matching is per byte: for each byte, the youngest pending store that writes that byte supplies it. Bytes no pending store covers come from the cache. A write-barrier input holds a busy indication until every parked store has been written to the cache.

Top module: `store_buffer`

## Requirements
- R1: After reset the queue is empty: `stall`, `own_req` and `wr_valid` are 0, and a raised `barrier_req` leaves `barrier_busy` at 0.
- R2: A store with `st_owned`=1 that arrives while the queue is empty is presented on the cache write port (`wr_valid`, `wr_addr`, `wr_data`, `wr_be`) in the same cycle and is not queued, so a later load to that address shows `ld_fwd`=0.
- R3: Any other store arriving while the queue is not full is queued without stalling. `own_req` is 1 while any queued entry lacks ownership. `own_req_line` then gives the line (address bits above the low `LINE_W`=2 word-offset bits) of the oldest such entry.
- R4: A queued entry leaves only after ownership of its line has been recorded. Recording happens when `grant_valid` is seen with a matching `grant_line` at a clock edge, or from `st_owned`=1 when the entry was queued. The cache write for the entry is presented in the cycle it leaves, so a grant given in cycle t produces its write no earlier than cycle t+1.
- R5: Queued stores reach the cache in store order, one per cycle at most. A younger entry that already owns its line waits behind an older entry that does not.
- R6: A load whose word address matches queued entries returns, for each byte b, data bits 8b+7..8b from the youngest matching entry whose `be` bit b is 1. The remaining bytes come from `cache_rd_data`, and `ld_fwd` is 1 when `ld_valid` is 1.
- R7: A load matching no queued entry returns `cache_rd_data` unchanged with `ld_fwd`=0.
- R8: With all `DEPTH`=4 entries in use, a presented store raises `stall` and is not accepted. `stall` stays high until the cycle after an entry has left.
- R9: While `barrier_req` is 1, `barrier_busy` is 1 exactly while the queue holds an entry. It falls in the cycle after the last write.
- R10: A grant marks every queued entry of the granted line, including entries that are not the oldest, so they later leave without a further grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store presented |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_owned | input | 1 | Cache currently owns the store's line for writing |
| stall | output | 1 | Store not accepted this cycle (queue full) |
| ld_valid | input | 1 | Load presented |
| ld_addr | input | AW | Load word address |
| cache_rd_data | input | DW | Cache data for the load address |
| ld_data | output | DW | Load result after merging queued stores |
| ld_fwd | output | 1 | At least one byte came from the queue |
| grant_valid | input | 1 | Cache reports ownership obtained |
| grant_line | input | AW-LINE_W | Line that became owned |
| own_req | output | 1 | Request to obtain ownership |
| own_req_line | output | AW-LINE_W | Line of the oldest entry lacking ownership |
| barrier_req | input | 1 | Write barrier in progress |
| barrier_busy | output | 1 | Barrier must keep waiting |
| wr_valid | output | 1 | Cache write this cycle |
| wr_addr | output | AW | Cache write word address |
| wr_data | output | DW | Cache write data |
| wr_be | output | DW/8 | Cache write byte enables |

## Verification
The cache write path is tried with three input patterns. A writable store into an empty queue must take the direct path. A store to a non-writable line must wait for its grant, which separates the direct path from the queued path. A writable store behind an unowned one must wait its turn, which separates store order from grant order. Forwarding is tried with three overlapping stores to one word under different byte masks, which tells youngest-per-byte merging apart from whole-word or oldest-first selection. A neighbouring word in the same line must miss, which exposes line-granular matching. A granted non-head line, a full queue with a pending store, and a barrier held across two separate grants show whether ownership marks every entry of a line, whether stall releases one cycle after a write, and whether the barrier clears only when the last entry has left.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
// sb_pkg: shared types of the store buffer.
// Assumes: nothing beyond the 1800-2017 language.
package sb_pkg;

    // Source of the single cache write port in a given cycle.
    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_DIRECT = 2'd1,
        WR_RETIRE = 2'd2
    } wr_src_e;

endpackage

// File: rtl/sb_ptrs.sv
`timescale 1ns/1ps
// sb_ptrs: head/tail pointers and occupancy of the entry ring.
// Assumes: DEPTH is a power of two, at least 2, so pointers wrap by
// plain overflow; push is never asserted while full, pop never while empty.
module sb_ptrs #(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [PW-1:0] head,
    output logic [PW-1:0] tail,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= tail + PW'(1);
            if (pop)  head <= head + PW'(1);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Occupancy flags.
    always_comb begin
        full  = (count == CW'(DEPTH));
        empty = (count == '0);
    end

endmodule

// File: rtl/sb_fwd_merge.sv
`timescale 1ns/1ps
// sb_fwd_merge: builds load data from the cache word overlaid, byte by
// byte, with the youngest queued store covering that byte.
// Assumes: entries head .. head+count-1 are live, oldest first.
module sb_fwd_merge #(
    parameter int DEPTH = 4,
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int BW = DW / 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [AW-1:0] ent_addr [DEPTH],
    input  logic [DW-1:0] ent_data [DEPTH],
    input  logic [BW-1:0] ent_be   [DEPTH],
    input  logic [PW-1:0] head,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] cache_data,
    output logic [DW-1:0] merged,
    output logic          hit
);

    // Walk oldest to youngest so a younger byte overwrites an older one.
    always_comb begin
        merged = cache_data;
        hit    = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [PW-1:0] idx;
            idx = head + PW'(k);
            if ((CW'(k) < count) && (ent_addr[idx] == ld_addr)) begin
                for (int b = 0; b < BW; b++) begin
                    if (ent_be[idx][b]) begin
                        merged[8*b +: 8] = ent_data[idx][8*b +: 8];
                        hit              = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/store_buffer.sv
`timescale 1ns/1ps
// store_buffer: in-order store queue in front of a data cache.
// Stores to lines not yet writable are queued and drain once ownership
// is granted; loads see the youngest queued bytes; a write barrier
// reports busy until the queue is empty.
// Assumes: DEPTH is a power of two; cache_rd_data is the cache word at
// ld_addr in the same cycle; a grant is never withdrawn while queued.
module store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LINE_W = 2,
    localparam int BW = DW / 8,
    localparam int LAW = AW - LINE_W,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           st_valid,
    input  logic [AW-1:0]  st_addr,
    input  logic [DW-1:0]  st_data,
    input  logic [BW-1:0]  st_be,
    input  logic           st_owned,
    output logic           stall,
    input  logic           ld_valid,
    input  logic [AW-1:0]  ld_addr,
    input  logic [DW-1:0]  cache_rd_data,
    output logic [DW-1:0]  ld_data,
    output logic           ld_fwd,
    input  logic           grant_valid,
    input  logic [LAW-1:0] grant_line,
    output logic           own_req,
    output logic [LAW-1:0] own_req_line,
    input  logic           barrier_req,
    output logic           barrier_busy,
    output logic           wr_valid,
    output logic [AW-1:0]  wr_addr,
    output logic [DW-1:0]  wr_data,
    output logic [BW-1:0]  wr_be
);

    logic [AW-1:0]    ent_addr [DEPTH];
    logic [DW-1:0]    ent_data [DEPTH];
    logic [BW-1:0]    ent_be   [DEPTH];
    logic [DEPTH-1:0] ent_own;

    logic [PW-1:0] head;
    logic [PW-1:0] tail;
    logic [CW-1:0] cnt;
    logic          full;
    logic          empty;
    logic          st_direct;
    logic          push;
    logic          retire;
    logic          grant_st;
    logic          fwd_hit;
    wr_src_e       wsrc;

    // Accept/route decisions for the incoming store.
    always_comb begin
        st_direct = st_valid && st_owned && empty;
        push      = st_valid && !st_direct && !full;
        stall     = st_valid && full;
        grant_st  = grant_valid && (grant_line == st_addr[AW-1:LINE_W]);
        retire    = !empty && ent_own[head];
    end

    sb_ptrs #(.DEPTH(DEPTH)) i_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (retire),
        .head  (head),
        .tail  (tail),
        .count (cnt),
        .full  (full),
        .empty (empty)
    );

    // Capture store payload into the tail entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push && (tail == PW'(i))) begin
                ent_addr[i] <= st_addr;
                ent_data[i] <= st_data;
                ent_be[i]   <= st_be;
            end
        end
    end

    // Ownership flag per entry: set at queueing or by a matching grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_own <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push && (tail == PW'(i))) begin
                    ent_own[i] <= st_owned || grant_st;
                end else if (grant_valid &&
                             (ent_addr[i][AW-1:LINE_W] == grant_line)) begin
                    ent_own[i] <= 1'b1;
                end
            end
        end
    end

    // Find the oldest live entry still lacking ownership.
    always_comb begin
        own_req      = 1'b0;
        own_req_line = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            logic [PW-1:0] idx;
            idx = head + PW'(k);
            if ((CW'(k) < cnt) && !ent_own[idx]) begin
                own_req      = 1'b1;
                own_req_line = ent_addr[idx][AW-1:LINE_W];
            end
        end
    end

    // Select the source of the cache write port.
    always_comb begin
        if (retire)         wsrc = WR_RETIRE;
        else if (st_direct) wsrc = WR_DIRECT;
        else                wsrc = WR_NONE;
    end

    // Drive the cache write port from the chosen source.
    always_comb begin
        wr_valid = 1'b0;
        wr_addr  = '0;
        wr_data  = '0;
        wr_be    = '0;
        case (wsrc)
            WR_RETIRE: begin
                wr_valid = 1'b1;
                wr_addr  = ent_addr[head];
                wr_data  = ent_data[head];
                wr_be    = ent_be[head];
            end
            WR_DIRECT: begin
                wr_valid = 1'b1;
                wr_addr  = st_addr;
                wr_data  = st_data;
                wr_be    = st_be;
            end
            default: ;
        endcase
    end

    sb_fwd_merge #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_fwd (
        .ent_addr   (ent_addr),
        .ent_data   (ent_data),
        .ent_be     (ent_be),
        .head       (head),
        .count      (cnt),
        .ld_addr    (ld_addr),
        .cache_data (cache_rd_data),
        .merged     (ld_data),
        .hit        (fwd_hit)
    );

    // Load-side and barrier status.
    always_comb begin
        ld_fwd       = ld_valid && fwd_hit;
        barrier_busy = barrier_req && !empty;
    end

endmodule

// File: rtl/sb_chk.sv
`timescale 1ns/1ps
// sb_chk: temporal checks on the store buffer, bound into every instance.
// Assumes: observes occupancy and port signals only.
module sb_chk #(
    parameter int DEPTH = 4,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt,
    input logic          st_valid,
    input logic          stall,
    input logic          wr_valid,
    input logic          own_req,
    input logic          barrier_req,
    input logic          barrier_busy
);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !wr_valid) |=> (cnt == $past(cnt)));

    // R2
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (cnt == '0)) |-> st_valid);

    // R5
    one_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> ((32'(cnt) + 32'd1) >= 32'($past(cnt))));

    // R3
    own_req_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        own_req |-> (cnt != '0));

    // R9
    barrier_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (barrier_req && $past(barrier_req) && $fell(barrier_busy)) |-> (cnt == '0));

endmodule

bind store_buffer sb_chk #(.DEPTH(DEPTH), .CW(CW)) i_sb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt          (cnt),
    .st_valid     (st_valid),
    .stall        (stall),
    .wr_valid     (wr_valid),
    .own_req      (own_req),
    .barrier_req  (barrier_req),
    .barrier_busy (barrier_busy)
);

// File: tb/test_store_buffer.sv
`timescale 1ns/1ps
// test_store_buffer: directed scenarios, one task each, self-checking.
module test_store_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic [15:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_be = '0;
    logic        st_owned = 1'b0;
    logic        stall;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_addr = '0;
    logic [31:0] cache_rd_data = '0;
    logic [31:0] ld_data;
    logic        ld_fwd;
    logic        grant_valid = 1'b0;
    logic [13:0] grant_line = '0;
    logic        own_req;
    logic [13:0] own_req_line;
    logic        barrier_req = 1'b0;
    logic        barrier_busy;
    logic        wr_valid;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] q_addr [$];
    logic [31:0] q_data [$];
    logic [3:0]  q_be   [$];

    always #2.5 clk = ~clk;

    store_buffer i_store_buffer (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_be(st_be), .st_owned(st_owned), .stall(stall),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .cache_rd_data(cache_rd_data),
        .ld_data(ld_data), .ld_fwd(ld_fwd),
        .grant_valid(grant_valid), .grant_line(grant_line),
        .own_req(own_req), .own_req_line(own_req_line),
        .barrier_req(barrier_req), .barrier_busy(barrier_busy),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
    );

    // Record every cache write mid-cycle.
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            q_addr.push_back(wr_addr);
            q_data.push_back(wr_data);
            q_be.push_back(wr_be);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        q_addr.delete();
        q_data.delete();
        q_be.delete();
    endtask

    // Move to just after the next rising edge and idle the request inputs.
    task automatic cycle();
        @(posedge clk);
        #1;
        st_valid    = 1'b0;
        st_owned    = 1'b0;
        ld_valid    = 1'b0;
        grant_valid = 1'b0;
    endtask

    task automatic mid();
        @(negedge clk);
    endtask

    task automatic put_store(input logic [15:0] a, input logic [31:0] d,
                             input logic [3:0] be, input logic own);
        cycle();
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be; st_owned = own;
    endtask

    task automatic give_grant(input logic [13:0] line);
        cycle();
        grant_valid = 1'b1;
        grant_line  = line;
    endtask

    task automatic t_reset();
        cycle();
        barrier_req = 1'b1;
        mid();
        chk("R1 stall", 32'(stall), 32'd0);
        chk("R1 own_req", 32'(own_req), 32'd0);
        chk("R1 wr_valid", 32'(wr_valid), 32'd0);
        chk("R1 barrier_busy", 32'(barrier_busy), 32'd0);
        barrier_req = 1'b0;
    endtask

    task automatic t_direct();
        clear_log();
        put_store(16'h0010, 32'hA5A5_0001, 4'hF, 1'b1);
        mid();
        chk("R2 wr_valid", 32'(wr_valid), 32'd1);
        chk("R2 wr_addr", 32'(wr_addr), 32'h0010);
        chk("R2 wr_data", wr_data, 32'hA5A5_0001);
        cycle();
        ld_valid = 1'b1; ld_addr = 16'h0010; cache_rd_data = 32'hDEAD_0000;
        mid();
        chk("R2 not queued ld_fwd", 32'(ld_fwd), 32'd0);
        chk("R7 ld_data", ld_data, 32'hDEAD_0000);
        chk("R2 own_req", 32'(own_req), 32'd0);
    endtask

    task automatic t_single();
        clear_log();
        put_store(16'h0020, 32'h1234_5678, 4'hF, 1'b0);
        mid();
        chk("R3 stall", 32'(stall), 32'd0);
        chk("R3 no direct write", 32'(wr_valid), 32'd0);
        cycle();
        ld_valid = 1'b1; ld_addr = 16'h0020; cache_rd_data = 32'h0;
        mid();
        chk("R3 own_req", 32'(own_req), 32'd1);
        chk("R3 own_req_line", 32'(own_req_line), 32'h8);
        chk("R6 ld_data", ld_data, 32'h1234_5678);
        chk("R6 ld_fwd", 32'(ld_fwd), 32'd1);
        give_grant(14'h8);
        mid();
        chk("R4 no write in grant cycle", 32'(wr_valid), 32'd0);
        cycle();
        mid();
        chk("R4 write after grant", 32'(wr_valid), 32'd1);
        chk("R4 wr_addr", 32'(wr_addr), 32'h0020);
        chk("R4 wr_data", wr_data, 32'h1234_5678);
        cycle();
        mid();
        chk("R4 drained own_req", 32'(own_req), 32'd0);
        chk("R4 drained wr_valid", 32'(wr_valid), 32'd0);
    endtask

    task automatic t_merge();
        clear_log();
        put_store(16'h0030, 32'h1111_1111, 4'b1111, 1'b0);
        put_store(16'h0030, 32'h2222_2222, 4'b0011, 1'b0);
        put_store(16'h0030, 32'h3333_3333, 4'b0010, 1'b0);
        cycle();
        ld_valid = 1'b1; ld_addr = 16'h0030; cache_rd_data = 32'hCCCC_CCCC;
        mid();
        chk("R6 youngest per byte", ld_data, 32'h1111_3322);
        cycle();
        ld_valid = 1'b1; ld_addr = 16'h0031; cache_rd_data = 32'hCCCC_CCCC;
        mid();
        chk("R7 same line other word data", ld_data, 32'hCCCC_CCCC);
        chk("R7 same line other word fwd", 32'(ld_fwd), 32'd0);
        give_grant(14'hC);
        for (int i = 0; i < 4; i++) cycle();
        mid();
        chk("R5 write count", 32'(q_addr.size()), 32'd3);
        if (q_addr.size() == 3) begin
            chk("R5 first", q_data[0], 32'h1111_1111);
            chk("R5 second", q_data[1], 32'h2222_2222);
            chk("R5 third", q_data[2], 32'h3333_3333);
            chk("R5 third be", 32'(q_be[2]), 32'h2);
        end
    endtask

    task automatic t_order();
        clear_log();
        put_store(16'h0040, 32'hAAAA_0040, 4'hF, 1'b0);
        put_store(16'h0050, 32'hBBBB_0050, 4'hF, 1'b1);
        put_store(16'h0044, 32'hCCCC_0044, 4'hF, 1'b0);
        cycle();
        mid();
        chk("R3 oldest unowned line", 32'(own_req_line), 32'h10);
        give_grant(14'h11);
        cycle();
        mid();
        chk("R5 owned younger waits", 32'(wr_valid), 32'd0);
        chk("R3 still oldest line", 32'(own_req_line), 32'h10);
        give_grant(14'h10);
        for (int i = 0; i < 4; i++) cycle();
        mid();
        chk("R10 all drained", 32'(q_addr.size()), 32'd3);
        if (q_addr.size() == 3) begin
            chk("R5 order 0", 32'(q_addr[0]), 32'h0040);
            chk("R5 order 1", 32'(q_addr[1]), 32'h0050);
            chk("R10 non-head grant kept", 32'(q_addr[2]), 32'h0044);
        end
    endtask

    task automatic t_full();
        clear_log();
        for (int i = 0; i < 4; i++)
            put_store(16'h0060 + 16'(i), 32'h6000_0000 + 32'(i), 4'hF, 1'b0);
        cycle();
        st_valid = 1'b1; st_addr = 16'h0064; st_data = 32'h6000_0004;
        st_be = 4'hF; st_owned = 1'b1;
        grant_valid = 1'b1; grant_line = 14'h18;
        mid();
        chk("R8 stall when full", 32'(stall), 32'd1);
        chk("R8 no write yet", 32'(wr_valid), 32'd0);
        cycle();
        st_valid = 1'b1; st_owned = 1'b1;
        mid();
        chk("R8 stall during retire", 32'(stall), 32'd1);
        chk("R8 retire write", 32'(wr_valid), 32'd1);
        cycle();
        st_valid = 1'b1; st_owned = 1'b1;
        mid();
        chk("R8 stall released", 32'(stall), 32'd0);
        for (int i = 0; i < 6; i++) cycle();
        mid();
        chk("R8 all five written", 32'(q_addr.size()), 32'd5);
        if (q_addr.size() == 5)
            chk("R8 late store last", 32'(q_addr[4]), 32'h0064);
    endtask

    task automatic t_barrier();
        clear_log();
        put_store(16'h0070, 32'h7000_0070, 4'hF, 1'b0);
        put_store(16'h0074, 32'h7000_0074, 4'hF, 1'b0);
        cycle();
        barrier_req = 1'b1;
        mid();
        chk("R9 busy pending", 32'(barrier_busy), 32'd1);
        give_grant(14'h1C);
        mid();
        chk("R9 busy at grant", 32'(barrier_busy), 32'd1);
        cycle();
        mid();
        chk("R9 first write", 32'(wr_addr), 32'h0070);
        chk("R9 busy while writing", 32'(barrier_busy), 32'd1);
        cycle();
        mid();
        chk("R9 busy one left", 32'(barrier_busy), 32'd1);
        chk("R3 next line requested", 32'(own_req_line), 32'h1D);
        give_grant(14'h1D);
        mid();
        chk("R9 busy second grant", 32'(barrier_busy), 32'd1);
        cycle();
        mid();
        chk("R9 last write", 32'(wr_addr), 32'h0074);
        chk("R9 busy on last write", 32'(barrier_busy), 32'd1);
        cycle();
        mid();
        chk("R9 busy cleared", 32'(barrier_busy), 32'd0);
        barrier_req = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_single();
        t_merge();
        t_order();
        t_full();
        t_barrier();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule